// File: doc/BRIEF.md
# Global-History XOR-Indexed Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It needs only the fetch PC and a shift register that records the outcomes of recent branches. Low PC bits are XORed with that global history. The result selects one entry in a table of 2-bit saturating counters. The guess comes back combinationally in the same fetch cycle.

Along with the guess, the block returns the table index it used and a snapshot of the history it read. The fetch side keeps both with the branch. When the branch resolves, the resolve stage sends back the index, the real outcome, a mispredict flag and the snapshot. The counter at that index moves toward the real outcome.

Each guess is shifted into the history at once, so younger branches see it without waiting. When a guess turns out wrong, the history is rebuilt from the returned snapshot with the real outcome shifted in.

Top module: `gxor_predictor`

## Requirements
- R1: `pred_index` equals `pred_pc[PC_LSB+HIST_W-1:PC_LSB]` XOR the current history, and `pred_hist` is the current history.
- R2: `pred_taken` is 1 exactly when the selected counter is 2'b10 or 2'b11. It is 0 for 2'b00 and 2'b01.
- R3: An update with `upd_taken`=1 raises the counter at `upd_index` by one. The counter stays at 2'b11 once there.
- R4: An update with `upd_taken`=0 lowers the counter at `upd_index` by one. The counter stays at 2'b00 once there.
- R5: When `pred_valid`=1 and there is no repair, the history on the next cycle is the old history shifted left by one, with `pred_taken` in bit 0.
- R6: When `upd_valid`=1 and `upd_mispredict`=1, the history on the next cycle is `upd_hist` shifted left by one, with `upd_taken` in bit 0. This repair takes priority over a `pred_valid` in the same cycle.
- R7: After reset, every counter holds 2'b10 (weakly taken) and the history is zero.
- R8: An update writes the counter named by `upd_index`, whatever the current history is.
- R9: When a read and an update select the same entry in the same cycle, the read returns the counter value from before the update.
- R10: With no `pred_valid` and no repair, the history keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_valid | input | 1 | A branch is being predicted this cycle; shift its guess into the history |
| pred_pc | input | PC_W | Fetch PC of the branch |
| pred_taken | output | 1 | Direction guess, 1 = taken |
| pred_index | output | HIST_W | Table index used for the guess |
| pred_hist | output | HIST_W | History snapshot used for the guess |
| upd_valid | input | 1 | A branch resolves this cycle |
| upd_index | input | HIST_W | Table index returned from the prediction |
| upd_taken | input | 1 | Real outcome, 1 = taken |
| upd_mispredict | input | 1 | The guess was wrong; repair the history |
| upd_hist | input | HIST_W | History snapshot returned from the prediction |

## Verification
The bench drives one counter down to 2'b00 and up to 2'b11, and then pushes it past each end. A design with no saturation check would wrap to the opposite strong state and flip its guess. Updates and reads are placed on the same entry in the same cycle. A table with write-through forwarding would return the new count one cycle too early. The bench sends mispredict repairs in the same cycle as a new prediction. A design that let the speculative shift win would leave wrong-path bits in the history, and every later index would be off. Updates are also sent after the history has moved on. A design that rebuilt the write index from the live history would train the wrong counter.

// File: rtl/gxp_pkg.sv
package gxp_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_TAKEN = 2'b10;

  // one step of a 2-bit saturating counter toward the observed outcome
  function automatic ctr_t ctr_next(input ctr_t cur, input logic taken);
    ctr_t nxt;
    nxt = cur;
    if (taken && cur != 2'b11)
      nxt = cur + 2'b01;
    else if (!taken && cur != 2'b00)
      nxt = cur - 2'b01;
    return nxt;
  endfunction

  // upper half of the counter range means taken
  function automatic logic ctr_says_taken(input ctr_t cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/ghist_reg.sv
module ghist_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         spec_en,
  input  logic         spec_bit,
  input  logic         fix_en,
  input  logic [W-1:0] fix_ckpt,
  input  logic         fix_bit,
  output logic [W-1:0] hist
);

  function automatic logic [W-1:0] shift_in(input logic [W-1:0] h, input logic b);
    return W'({h, b});
  endfunction

  logic [W-1:0] hist_q;
  logic [W-1:0] hist_d;

  always_comb begin
    hist_d = hist_q;
    if (fix_en)
      hist_d = shift_in(fix_ckpt, fix_bit);
    else if (spec_en)
      hist_d = shift_in(hist_q, spec_bit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      hist_q <= '0;
    else
      hist_q <= hist_d;
  end

  assign hist = hist_q;

  p_spec_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_en && !fix_en) |=> (hist_q[0] == $past(spec_bit)) &&
                             ((hist_q >> 1) == ($past(hist_q) & {1'b0, {(W-1){1'b1}}})));

  p_repair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fix_en |=> (hist_q[0] == $past(fix_bit)) &&
               ((hist_q >> 1) == ($past(fix_ckpt) & {1'b0, {(W-1){1'b1}}})));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!spec_en && !fix_en) |=> $stable(hist_q));

endmodule

// File: rtl/ctr_table.sv
module ctr_table
  import gxp_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);

  localparam int DEPTH = 1 << IDX_W;

  ctr_t ctrs [DEPTH];

  generate
    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      logic hit;
      assign hit = wr_en && (wr_idx == IDX_W'(e));
      always_ff @(posedge clk) begin
        if (!rst_n)
          ctrs[e] <= CTR_WEAK_TAKEN;
        else if (hit)
          ctrs[e] <= ctr_next(ctrs[e], wr_taken);
      end
    end
  endgenerate

  // read is taken from the registers, so a same-cycle write is not seen yet
  assign rd_ctr = ctrs[rd_idx];

  // value the write port sees before it changes, brought out for checks
  ctr_t wr_old;
  assign wr_old = ctrs[wr_idx];

  p_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && wr_old != 2'b11) |=> ctrs[$past(wr_idx)] == ctr_t'($past(wr_old) + 2'b01));

  p_sat_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && wr_old == 2'b11) |=> ctrs[$past(wr_idx)] == 2'b11);

  p_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken && wr_old != 2'b00) |=> ctrs[$past(wr_idx)] == ctr_t'($past(wr_old) - 2'b01));

  p_sat_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken && wr_old == 2'b00) |=> ctrs[$past(wr_idx)] == 2'b00);

  p_idle_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_idx) |-> $stable(rd_ctr));

endmodule

// File: rtl/gxor_predictor.sv
module gxor_predictor
  import gxp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int HIST_W = 8,
  parameter int PC_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pred_valid,
  input  logic [PC_W-1:0]   pred_pc,
  output logic              pred_taken,
  output logic [HIST_W-1:0] pred_index,
  output logic [HIST_W-1:0] pred_hist,
  input  logic              upd_valid,
  input  logic [HIST_W-1:0] upd_index,
  input  logic              upd_taken,
  input  logic              upd_mispredict,
  input  logic [HIST_W-1:0] upd_hist
);

  localparam int IDX_W = HIST_W;

  function automatic logic [IDX_W-1:0] hash_index(input logic [PC_W-1:0] pc,
                                                  input logic [HIST_W-1:0] h);
    return pc[PC_LSB +: IDX_W] ^ h;
  endfunction

  logic [HIST_W-1:0] hist_now;
  logic [IDX_W-1:0]  rd_idx;
  ctr_t              rd_ctr;
  logic              guess;
  logic              repair;

  assign repair = upd_valid && upd_mispredict;
  assign rd_idx = hash_index(pred_pc, hist_now);
  assign guess  = ctr_says_taken(rd_ctr);

  ghist_reg #(.W(HIST_W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .spec_en  (pred_valid),
    .spec_bit (guess),
    .fix_en   (repair),
    .fix_ckpt (upd_hist),
    .fix_bit  (upd_taken),
    .hist     (hist_now)
  );

  ctr_table #(.IDX_W(IDX_W)) u_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (rd_idx),
    .rd_ctr   (rd_ctr),
    .wr_en    (upd_valid),
    .wr_idx   (upd_index),
    .wr_taken (upd_taken)
  );

  assign pred_taken = guess;
  assign pred_index = rd_idx;
  assign pred_hist  = hist_now;

  p_chain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && !repair) |=> pred_hist[0] == $past(pred_taken));

  p_repair_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && repair) |=> pred_hist[0] == $past(upd_taken));

endmodule

// File: tb/tb_gxor_predictor.sv
module tb_gxor_predictor;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pred_valid;
  logic [31:0] pred_pc;
  logic        pred_taken;
  logic [7:0]  pred_index;
  logic [7:0]  pred_hist;
  logic        upd_valid;
  logic [7:0]  upd_index;
  logic        upd_taken;
  logic        upd_mispredict;
  logic [7:0]  upd_hist;

  always #2 clk = ~clk;

  gxor_predictor #(.PC_W(32), .HIST_W(8), .PC_LSB(2)) dut (
    .clk(clk), .rst_n(rst_n),
    .pred_valid(pred_valid), .pred_pc(pred_pc),
    .pred_taken(pred_taken), .pred_index(pred_index), .pred_hist(pred_hist),
    .upd_valid(upd_valid), .upd_index(upd_index), .upd_taken(upd_taken),
    .upd_mispredict(upd_mispredict), .upd_hist(upd_hist)
  );

  typedef struct {
    logic       tk;
    logic [7:0] idx;
    logic [7:0] hist;
    string      req;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  logic [1:0] m_ctr [256];
  logic [7:0] m_ghr;
  logic [7:0] ckpt;

  // monitor: compares the outputs after they settle, away from the edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks += 3;
        if (pred_taken !== e.tk) begin
          errors++;
          $display("FAIL %s: pred_taken got %0b exp %0b", e.req, pred_taken, e.tk);
        end
        if (pred_index !== e.idx) begin
          errors++;
          $display("FAIL %s: pred_index got %02h exp %02h", e.req, pred_index, e.idx);
        end
        if (pred_hist !== e.hist) begin
          errors++;
          $display("FAIL %s: pred_hist got %02h exp %02h", e.req, pred_hist, e.hist);
        end
      end
    end
  end

  // driver: one cycle of stimulus plus the expected outputs for that cycle
  task automatic step(input logic pv, input logic [31:0] pc, input logic uv,
                      input logic [7:0] ui, input logic ut, input logic um,
                      input logic [7:0] uh, input string req);
    exp_t e;
    @(negedge clk);
    pred_valid = pv; pred_pc = pc;
    upd_valid = uv; upd_index = ui; upd_taken = ut;
    upd_mispredict = um; upd_hist = uh;
    e.idx  = pc[9:2] ^ m_ghr;
    e.tk   = (m_ctr[e.idx] >= 2'd2);
    e.hist = m_ghr;
    e.req  = req;
    q.push_back(e);
    if (uv) begin
      if (ut && m_ctr[ui] < 2'd3) m_ctr[ui] = m_ctr[ui] + 2'd1;
      if (!ut && m_ctr[ui] > 2'd0) m_ctr[ui] = m_ctr[ui] - 2'd1;
    end
    if (uv && um) m_ghr = {uh[6:0], ut};
    else if (pv)  m_ghr = {m_ghr[6:0], e.tk};
  endtask

  function automatic logic [31:0] pc_for(input logic [7:0] idx);
    logic [21:0] hi;
    hi = 22'($urandom);
    return {hi, idx ^ m_ghr, 2'b00};
  endfunction

  task automatic probe(input logic [7:0] idx, input string req);
    step(1'b0, pc_for(idx), 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, req);
  endtask

  task automatic train(input logic [7:0] idx, input logic ut, input string req);
    step(1'b0, pc_for(8'h00), 1'b1, idx, ut, 1'b0, 8'h00, req);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog: run hung, got timeout exp completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) m_ctr[i] = 2'b10;
    m_ghr = 8'h00;
    rst_n = 1'b0;
    pred_valid = 0; pred_pc = 0; upd_valid = 0; upd_index = 0;
    upd_taken = 0; upd_mispredict = 0; upd_hist = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R7: weakly taken everywhere, history clear
    step(1'b0, 32'h0, 1'b0, 8'h0, 1'b0, 1'b0, 8'h0, "R7");
    step(1'b0, 32'h0000_03FC, 1'b0, 8'h0, 1'b0, 1'b0, 8'h0, "R7");
    probe(8'h81, "R7");

    // R1 R5: speculative shifts feed the next index
    for (int i = 0; i < 6; i++)
      step(1'b1, $urandom, 1'b0, 8'h0, 1'b0, 1'b0, 8'h0, "R1 R5");

    // R10: idle cycles leave history alone
    for (int i = 0; i < 3; i++)
      step(1'b0, $urandom, 1'b0, 8'h0, 1'b0, 1'b0, 8'h0, "R10");

    // R9: read and write of the same entry in one cycle returns the old value
    step(1'b0, pc_for(8'h3C), 1'b1, 8'h3C, 1'b0, 1'b0, 8'h0, "R9");
    probe(8'h3C, "R9");

    // R4 / R2: walk down to 00 and past it
    for (int i = 0; i < 3; i++) begin
      train(8'h3C, 1'b0, "R4");
      probe(8'h3C, "R4 R2");
    end

    // R3 / R2: walk up to 11 and past it
    for (int i = 0; i < 5; i++) begin
      train(8'h3C, 1'b1, "R3");
      probe(8'h3C, "R3 R2");
    end
    train(8'h3C, 1'b0, "R3");
    probe(8'h3C, "R3");

    // R8: write goes to the given index after the history moved on
    for (int i = 0; i < 4; i++)
      step(1'b1, $urandom, 1'b0, 8'h0, 1'b0, 1'b0, 8'h0, "R5");
    train(8'hA5, 1'b0, "R8");
    probe(8'hA5, "R8 R2");
    train(8'hA5, 1'b0, "R8");
    probe(8'hA5, "R8");

    // R6: repair with a same-cycle prediction
    ckpt = m_ghr;
    for (int i = 0; i < 3; i++)
      step(1'b1, $urandom, 1'b0, 8'h0, 1'b0, 1'b0, 8'h0, "R5");
    step(1'b1, $urandom, 1'b1, 8'h11, 1'b0, 1'b1, ckpt, "R6");
    probe(8'h11, "R6");
    step(1'b1, $urandom, 1'b1, 8'h12, 1'b1, 1'b1, 8'h5A, "R6");
    probe(8'h12, "R6");

    // mixed traffic
    for (int i = 0; i < 400; i++)
      step(1'($urandom), $urandom, 1'($urandom), 8'($urandom), 1'($urandom),
           1'($urandom), 8'($urandom), "R1 R3 R4 R5 R6");

    repeat (3) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule